// File: doc/BRIEF.md
# Cascadable Priority Encoder

This block turns a vector of active-high request lines into the binary index of the highest-numbered line that is set. It is built from identical eight-lane encoder stages. Each stage has an enable input and an enable output, and its enable output is high only when the stage is enabled and none of its own lanes is requesting. The stages are chained from the most significant stage down to the least significant one. Only the highest-placed stage that holds a request reports an index, and every stage below it is switched off.

The top module wraps a parameterised number of stages into one wide encoder. The low three bits of the result come from the reporting stage. The upper bits give that stage's position in the chain. The group flag reports whether any lane requested. The chain's final enable output lets several of these blocks be cascaded in turn. All logic is combinational, so every output follows its inputs in the same cycle.

Top module: `prio_chain`

## Requirements
- R1: With `en_in` low, `idx`, `grp` and `en_out` are all 0, whatever `req` holds.
- R2: With `en_in` high and `req` all zero, `idx` is 0, `grp` is 0 and `en_out` is 1.
- R3: With `en_in` high and at least one `req` bit set, `grp` is 1 and `en_out` is 0; `grp` and `en_out` are never high together.
- R4: Within one eight-lane stage, lane 7 has the highest priority and lane 0 the lowest. The stage's 3-bit index is the binary lane number of its highest set lane (lane 7 gives 3'b111, lane 0 gives 3'b000), and the lanes below that one have no effect on it.
- R5: Stage s serves `req[8*s+7:8*s]`. The top stage is enabled by `en_in`, and each stage passes its enable output to the stage just below it. A stage therefore reports only when `en_in` is high and every lane above its own slice is clear.
- R6: The wide `idx` is {stage number, lane index}: bits [2:0] hold the lane index in the reporting stage and the upper bits hold that stage's number. It equals the bit position of the highest set bit of `req`.
- R7: The number of stages is the parameter `STAGES`; `req` is 8*STAGES bits wide and `idx` is 3+clog2(STAGES) bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req | input | 8*STAGES | Request lines, bit 0 lowest priority |
| en_in | input | 1 | Enable for the whole chain |
| idx | output | 3+clog2(STAGES) | Bit position of the highest set request |
| grp | output | 1 | High when enabled and any request is set |
| en_out | output | 1 | High when enabled and no request is set; drives a following chain |

## Verification
The block holds no state, so an internal fault shows at the ports in the same cycle that the input pattern exposes it. A broken enable link between stages shows up as a lower stage reporting while a higher lane is set, which gives a wrong upper index field or a wrong low field. Each of the 256 single-stage patterns is applied with the enable both low and high, both in the bottom stage and in the top stage. Random wide vectors then cover the mixed cases, so a wrong lane decode, a wrong stage number or a wrong flag appears on the first vector that reaches it.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;

    localparam int LANES  = 8;
    localparam int LANE_W = $clog2(LANES);

    typedef logic [LANES-1:0]  lane_vec_t;
    typedef logic [LANE_W-1:0] lane_idx_t;

    // Result of one eight-lane stage
    typedef struct packed {
        lane_idx_t idx;   // highest active lane
        logic      grp;   // some lane active while enabled
        logic      pass;  // enabled and idle: enables next stage
    } stage_res_t;

    // Highest set lane; later iterations overwrite earlier ones
    function automatic lane_idx_t top_lane(input lane_vec_t v);
        lane_idx_t r;
        r = '0;
        for (int i = 0; i < LANES; i++) begin
            if (v[i]) r = LANE_W'(i);
        end
        return r;
    endfunction

    function automatic int upper_width(input int stages);
        return (stages > 1) ? $clog2(stages) : 1;
    endfunction

endpackage

// File: rtl/prio_stage.sv
module prio_stage
    import prio_enc_pkg::*;
(
    input  lane_vec_t  req,
    input  logic       en_in,
    output stage_res_t res
);

    always_comb begin
        res = '0;
        if (en_in) begin
            if (|req) begin
                res.grp = 1'b1;
                res.idx = top_lane(req);
            end else begin
                res.pass = 1'b1;
            end
        end
    end

endmodule

// File: rtl/prio_merge.sv
module prio_merge
    import prio_enc_pkg::*;
#(
    parameter int STAGES = 2,
    localparam int HW    = upper_width(STAGES)
) (
    input  stage_res_t        st [STAGES],
    output lane_idx_t         lo,
    output logic [HW-1:0]     hi,
    output logic              grp
);

    // At most one stage reports, so OR-merging is exact
    always_comb begin
        lo  = '0;
        hi  = '0;
        grp = 1'b0;
        for (int s = 0; s < STAGES; s++) begin
            lo  = lo | st[s].idx;
            grp = grp | st[s].grp;
            if (st[s].grp) hi = hi | HW'(s);
        end
    end

endmodule

// File: rtl/prio_chain.sv
module prio_chain
    import prio_enc_pkg::*;
#(
    parameter int STAGES  = 2,
    localparam int REQ_W  = LANES * STAGES,
    localparam int UPW    = (STAGES > 1) ? $clog2(STAGES) : 0,
    localparam int OUT_W  = LANE_W + UPW,
    localparam int HW     = upper_width(STAGES)
) (
    input  logic [REQ_W-1:0] req,
    input  logic             en_in,
    output logic [OUT_W-1:0] idx,
    output logic             grp,
    output logic             en_out
);

    logic [STAGES:0] en_link;
    stage_res_t      st [STAGES];
    lane_idx_t       lo;
    logic [HW-1:0]   hi;

    assign en_link[STAGES] = en_in;

    // Top stage first; each enable output feeds the stage below (R5)
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        prio_stage u_stage (
            .req   (req[s*LANES +: LANES]),
            .en_in (en_link[s+1]),
            .res   (st[s])
        );
        assign en_link[s] = st[s].pass;
    end

    prio_merge #(.STAGES(STAGES)) u_merge (
        .st  (st),
        .lo  (lo),
        .hi  (hi),
        .grp (grp)
    );

    if (UPW > 0) begin : g_wide
        assign idx = {hi[UPW-1:0], lo};
    end else begin : g_single
        assign idx = lo;
    end

    assign en_out = en_link[0];

endmodule

// File: rtl/prio_chain_chk.sv
module prio_chain_chk
    import prio_enc_pkg::*;
#(
    parameter int STAGES = 2,
    localparam int REQ_W = LANES * STAGES,
    localparam int UPW   = (STAGES > 1) ? $clog2(STAGES) : 0,
    localparam int OUT_W = LANE_W + UPW
) (
    input logic [REQ_W-1:0] req,
    input logic             en_in,
    input logic [OUT_W-1:0] idx,
    input logic             grp,
    input logic             en_out
);

    always_comb begin
        if (!en_in) begin
            p_all_low_off_r1: assert (idx == '0 && !grp && !en_out);
        end
        if (en_in && req == '0) begin
            p_idle_passes_r2: assert (idx == '0 && !grp && en_out);
        end
        if (en_in && req != '0) begin
            p_active_flags_r3: assert (grp && !en_out);
        end
        p_flags_exclusive_r3: assert (!(grp && en_out));
        if (grp) begin
            // R4/R6: bit idx set, nothing above it
            p_highest_bit_r6: assert ((req >> idx) == REQ_W'(1));
        end
    end

endmodule

bind prio_chain prio_chain_chk #(.STAGES(STAGES)) u_chk (
    .req    (req),
    .en_in  (en_in),
    .idx    (idx),
    .grp    (grp),
    .en_out (en_out)
);

// File: tb/prio_chain_test.sv
module prio_chain_test;

    localparam int CLK_PERIOD = 10;
    localparam int STAGES     = 2;
    localparam int REQ_W      = 8 * STAGES;
    localparam int OUT_W      = 3 + $clog2(STAGES);
    localparam int ROW_W      = 1 + REQ_W + OUT_W + 2;
    localparam int NROWS      = 12;

    // {en_in, req, idx, grp, en_out}
    localparam logic [ROW_W-1:0] TABLE [NROWS] = '{
        {1'b1, 16'h0000, 4'd0,  1'b0, 1'b1},
        {1'b0, 16'hFFFF, 4'd0,  1'b0, 1'b0},
        {1'b1, 16'h8000, 4'd15, 1'b1, 1'b0},
        {1'b1, 16'h0001, 4'd0,  1'b1, 1'b0},
        {1'b1, 16'h0100, 4'd8,  1'b1, 1'b0},
        {1'b1, 16'h00FF, 4'd7,  1'b1, 1'b0},
        {1'b1, 16'h0180, 4'd8,  1'b1, 1'b0},
        {1'b1, 16'h7FFF, 4'd14, 1'b1, 1'b0},
        {1'b1, 16'h0080, 4'd7,  1'b1, 1'b0},
        {1'b1, 16'h0200, 4'd9,  1'b1, 1'b0},
        {1'b1, 16'h0021, 4'd5,  1'b1, 1'b0},
        {1'b0, 16'h0001, 4'd0,  1'b0, 1'b0}
    };

    logic             clk = 1'b0;
    logic [REQ_W-1:0] req;
    logic             en_in;
    logic [OUT_W-1:0] idx;
    logic             grp;
    logic             en_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_chain #(.STAGES(STAGES)) uut (
        .req    (req),
        .en_in  (en_in),
        .idx    (idx),
        .grp    (grp),
        .en_out (en_out)
    );

    // Behavioural reference: {idx, grp, en_out}
    function automatic logic [OUT_W+1:0] model(input logic e, input logic [REQ_W-1:0] r);
        logic [OUT_W-1:0] p;
        if (!e) return '0;
        if (r == '0) return {{OUT_W{1'b0}}, 1'b0, 1'b1};
        p = '0;
        for (int i = REQ_W - 1; i >= 0; i--) begin
            if (r[i]) begin
                p = OUT_W'(i);
                break;
            end
        end
        return {p, 1'b1, 1'b0};
    endfunction

    task automatic compare(input string tag, input logic [OUT_W+1:0] exp);
        logic [OUT_W+1:0] got;
        got = {idx, grp, en_out};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: en_in=%0b req=%h got idx=%0d grp=%0b en_out=%0b expected idx=%0d grp=%0b en_out=%0b",
                     tag, en_in, req, got[OUT_W+1:2], got[1], got[0],
                     exp[OUT_W+1:2], exp[1], exp[0]);
        end
    endtask

    task automatic apply(input logic e, input logic [REQ_W-1:0] r);
        @(negedge clk);
        en_in = e;
        req   = r;
        #1;
    endtask

    task automatic run_ref(input string tag, input logic e, input logic [REQ_W-1:0] r);
        apply(e, r);
        compare(tag, model(e, r));
    endtask

    initial begin
        en_in = 1'b0;
        req   = '0;
        @(negedge clk);
        #1;
        compare("R1 initial state", '0);

        // Directed table
        for (int n = 0; n < NROWS; n++) begin
            apply(TABLE[n][ROW_W-1], TABLE[n][ROW_W-2 -: REQ_W]);
            compare("R4 R5 R6 table", TABLE[n][OUT_W+1:0]);
        end

        // Every single-stage pattern in the bottom stage
        for (int p = 0; p < 256; p++) begin
            run_ref("R1 bottom stage disabled", 1'b0, REQ_W'(p));
            run_ref((p == 0) ? "R2 bottom stage idle" : "R3 R4 bottom stage lanes",
                    1'b1, REQ_W'(p));
        end

        // Every pattern in the top stage, random bits below
        for (int p = 0; p < 256; p++) begin
            logic [7:0] below;
            below = 8'($urandom);
            run_ref("R1 top stage disabled", 1'b0, {8'(p), below});
            run_ref("R5 top stage masks lower", 1'b1, {8'(p), below});
        end

        // Random wide vectors
        for (int k = 0; k < 400; k++) begin
            logic [REQ_W-1:0] r;
            r = REQ_W'($urandom);
            if (k % 4 == 1) r = r >> ($urandom % REQ_W);
            run_ref("R6 R7 random wide", (k % 8) != 7, r);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule